// File: doc/BRIEF.md
# Dual Split-Section Decade Counter

This block holds two decade counters that run independently. Each counter has two stages: a toggle stage that divides by two, and a stage that counts modulo five. Each stage takes its own stage-clock input and advances when that input goes from high to low. A two-bit mode field on each counter sets how the stages connect inside it:

- Split mode leaves both stages on their own external clocks.
- BCD mode has the toggle output clock the modulo-five stage, so the counter runs 0 to 9 in binary-coded decimal.
- Bi-quinary mode has the top bit of the modulo-five stage clock the toggle stage. The toggle bit then becomes a square-wave decade output.

An optional link feeds one output bit of the first counter into a chosen stage clock of the second counter. This cascade gives division ratios of 2, 4, 5, 10, 20, 25, 50 and 100.

The stage-clock inputs are level signals that a system clock samples. A stage steps on the first system-clock edge after its input has fallen. A stage that is driven internally sees its source fall one system cycle later, which models the ripple. Each counter has an active-high clear. The clear forces that counter's four outputs low at once, without waiting for a clock edge, and holds its stages at zero for as long as it stays high. A synchronous active-low system reset initialises everything.

Top module: `dual_decade_counter`

## Requirements
- R1: The toggle stage inverts its output bit q[0] of the counter on every falling edge of its stage clock, and holds it otherwise.
- R2: The modulo-five stage counts 0,1,2,3,4 in binary on q[3:1] of the counter and returns to 0 on the fifth falling edge of its stage clock.
- R3: Mode 2'b01 (BCD) clocks the modulo-five stage from q[0], which ignores the external cp1. Mode 2'b00 or 2'b11 (split) clocks the toggle stage from cp0 and the modulo-five stage from cp1. In BCD mode, q counts 0 to 9 in BCD on successive cp0 falls and wraps to 0.
- R4: Mode 2'b10 (bi-quinary) clocks the toggle stage from q[3], which ignores the external cp0. Over ten consecutive cp1 falls from zero, q[0] is high for exactly five of the ten counts.
- R5: While a counter's mr bit is high, that counter's four outputs read zero in the same cycle, without waiting for a clock edge. The other counter is unaffected. Raising both mr bits clears all eight outputs.
- R6: Stage-clock falls that occur while mr is high are ignored. After mr is released with the stage clock high, the first fall moves the count from 0 to 1.
- R7: When link_en is 1, counter 1's stage clock that link_dst selects (0 = toggle stage, 1 = modulo-five stage) is taken from counter 0's q[0] (link_src = 0) or q[3] (link_src = 1), and the external pin for that stage is ignored.
- R8: The linked configurations divide as follows, with counter 0 on q[3:0] and counter 1 on q[7:4]:
  - Both counters in BCD, linked q[3] to the toggle stage: a decimal count to 99 that returns to 00 on the 100th fall.
  - Both counters split, linked q[0] to the toggle stage: divide by 4.
  - Both counters split, linked q[3] to the modulo-five stage: divide by 25.
- R9: While rst_n is low at a clk rising edge, all stages clear to zero. Each internal link adds one clk cycle of ripple latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the stage-clock levels |
| rst_n | input | 1 | Synchronous active-low system reset |
| mode | input | 2*NUM_UNITS | Per-counter chaining mode, 2 bits each |
| cp0 | input | NUM_UNITS | External toggle-stage clock level per counter |
| cp1 | input | NUM_UNITS | External modulo-five-stage clock level per counter |
| mr | input | NUM_UNITS | Per-counter active-high clear |
| link_en | input | NUM_UNITS-1 | Enables feeding counter u-1 into counter u |
| link_src | input | NUM_UNITS-1 | Link source bit: 0 = q[0], 1 = q[3] of the lower counter |
| link_dst | input | NUM_UNITS-1 | Link target: 0 = toggle stage, 1 = modulo-five stage |
| q | output | 4*NUM_UNITS | Count outputs, four bits per counter |

## Verification
The bench checks the corner cases where these errors would show:

- **Wrap points.** The modulo-five stage wraps from 4 and the BCD count wraps from 9 to 0. A counter with the wrong modulus would show 5 or 10 there.
- **Which input is ignored.** In BCD mode the external cp1 must have no effect, and in bi-quinary mode cp0 must have no effect. A wrong chaining mux would let those pulses move the count.
- **The clear.** Outputs must read zero within the same cycle, and no fall may be counted while the clear is held. A clear that only acts at a clock edge, or one that lets falls through, would leave a non-zero value.
- **The link.** The 100-count run crosses two decimal carries, and the divide-by-4 and divide-by-25 runs take their link from a different source bit. A link with the wrong source bit, or one that misses falls, would stop the upper digit from stepping or step it at the wrong count.
- **Duty cycle.** The bench counts the bi-quinary duty cycle of q[0] directly, so a toggle stage placed on the wrong side of the chain would fail.

// File: rtl/dsdc_pkg.sv
// Shared types for the dual split-section decade counter.
package dsdc_pkg;
    // Chaining selection for one decade; 2'b11 behaves as split.
    typedef enum logic [1:0] {
        MODE_SPLIT     = 2'b00,
        MODE_BCD       = 2'b01,
        MODE_BIQ       = 2'b10,
        MODE_SPLIT_ALT = 2'b11
    } chain_mode_e;

    localparam int DIV_HI_MODULUS = 5;
    localparam int DIV_HI_BITS    = $clog2(DIV_HI_MODULUS);
    localparam int UNIT_BITS      = DIV_HI_BITS + 1;
endpackage

// File: rtl/dsdc_fall_detect.sv
// Falling-edge detector for a stage-clock level.
// What it does: reports a one-cycle pulse on the first clk edge after lvl
// has gone from high to low.
// Assumptions: lvl is stable around the clk rising edge. The clear forces
// the history low, so a level that goes low while the clear is high is
// never counted as a fall.
module dsdc_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    // Remember the level seen at the previous clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   prev_q <= 1'b0;
        else if (clr) prev_q <= 1'b0;
        else          prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl & ~clr;
endmodule

// File: rtl/dsdc_div2_stage.sv
// Divide-by-two stage of one decade.
// What it does: flips its bit on each step pulse.
// Assumptions: step is a single-cycle pulse from a fall detector. The clear
// has priority over step.
module dsdc_div2_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic bit_q
);
    // Toggle on step, zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    bit_q <= 1'b0;
        else if (clr)  bit_q <= 1'b0;
        else if (step) bit_q <= ~bit_q;
    end

    p_div2_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (bit_q != $past(bit_q)));
    p_div2_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(bit_q));
    p_div2_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bit_q == 1'b0));
endmodule

// File: rtl/dsdc_div5_stage.sv
// Modulo-N counting stage (five by default) of one decade.
// What it does: counts up in binary on each step and returns to zero after
// MODULUS-1. Any value at or above MODULUS-1 also returns to zero, so an
// out-of-range state recovers on the next step.
// Assumptions: step is a single-cycle pulse. The clear has priority.
module dsdc_div5_stage #(
    parameter int MODULUS = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       step,
    output logic [$clog2(MODULUS)-1:0] cnt_q
);
    localparam int W = $clog2(MODULUS);
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    // Count with wrap, zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (step) begin
            if (cnt_q >= LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    p_div5_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && cnt_q == LAST) |=> (cnt_q == '0));
    p_div5_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_div5_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt_q));
    p_div5_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/dsdc_decade_unit.sv
// One decade: a divide-by-two stage plus a modulo-five stage.
// What it does: chooses the clock source of each stage from the mode
// (split, BCD, bi-quinary), detects falls, and masks the outputs while the
// clear is high.
// Assumptions: cp0_in and cp1_in already carry any link from a lower unit.
// The mode is changed only while the clear is high.
module dsdc_decade_unit
    import dsdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 cp0_in,
    input  logic                 cp1_in,
    input  logic                 mr,
    output logic [UNIT_BITS-1:0] q
);
    chain_mode_e           m;
    logic                  lo_q;
    logic [DIV_HI_BITS-1:0] hi_q;
    logic                  lvl_lo, lvl_hi;
    logic                  step_lo, step_hi;

    assign m = chain_mode_e'(mode);

    // Select each stage clock: internal chaining or the external pin.
    always_comb begin
        lvl_lo = (m == MODE_BIQ) ? hi_q[DIV_HI_BITS-1] : cp0_in;
        lvl_hi = (m == MODE_BCD) ? lo_q : cp1_in;
    end

    dsdc_fall_detect u_fd_lo (
        .clk(clk), .rst_n(rst_n), .clr(mr), .lvl(lvl_lo), .fall(step_lo)
    );
    dsdc_fall_detect u_fd_hi (
        .clk(clk), .rst_n(rst_n), .clr(mr), .lvl(lvl_hi), .fall(step_hi)
    );

    dsdc_div2_stage u_lo (
        .clk(clk), .rst_n(rst_n), .clr(mr), .step(step_lo), .bit_q(lo_q)
    );
    dsdc_div5_stage #(.MODULUS(DIV_HI_MODULUS)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(mr), .step(step_hi), .cnt_q(hi_q)
    );

    // The clear acts on the outputs at once, ahead of the clock.
    always_comb begin
        q = mr ? '0 : {hi_q, lo_q};
    end

    p_unit_mr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mr |=> (hi_q == '0 && lo_q == 1'b0));
    p_unit_bcd_ignore_cp1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m == MODE_BCD && !mr && $past(m == MODE_BCD) && !step_lo && !$past(step_lo))
        |=> $stable(hi_q));
    p_unit_biq_ignore_cp0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m == MODE_BIQ && !mr && $past(m == MODE_BIQ) && !step_hi && !$past(step_hi))
        |=> $stable(lo_q));
endmodule

// File: rtl/dual_decade_counter.sv
// Top: a chain of split-section decade units (two by default).
// What it does: routes each unit's external stage clocks, optionally
// replacing one of them with an output bit of the unit below (the cascade).
// Assumptions: NUM_UNITS >= 2. Unit 0 has no link.
module dual_decade_counter
    import dsdc_pkg::*;
#(
    parameter int NUM_UNITS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2*NUM_UNITS-1:0]         mode,
    input  logic [NUM_UNITS-1:0]           cp0,
    input  logic [NUM_UNITS-1:0]           cp1,
    input  logic [NUM_UNITS-1:0]           mr,
    input  logic [NUM_UNITS-2:0]           link_en,
    input  logic [NUM_UNITS-2:0]           link_src,
    input  logic [NUM_UNITS-2:0]           link_dst,
    output logic [UNIT_BITS*NUM_UNITS-1:0] q
);
    localparam int NUM_LINKS = NUM_UNITS - 1;

    logic [UNIT_BITS-1:0] q_unit [NUM_UNITS];
    logic [NUM_UNITS-1:0] eff_cp0, eff_cp1;

    // Unit 0 always takes its own pins.
    assign eff_cp0[0] = cp0[0];
    assign eff_cp1[0] = cp1[0];

    genvar u;
    generate
        for (u = 1; u <= NUM_LINKS; u++) begin : g_link
            logic src;
            // Pick the lower unit's tap and steer it to the chosen stage.
            always_comb begin
                src        = link_src[u-1] ? q_unit[u-1][UNIT_BITS-1] : q_unit[u-1][0];
                eff_cp0[u] = (link_en[u-1] && !link_dst[u-1]) ? src : cp0[u];
                eff_cp1[u] = (link_en[u-1] &&  link_dst[u-1]) ? src : cp1[u];
            end
        end

        for (u = 0; u < NUM_UNITS; u++) begin : g_unit
            dsdc_decade_unit u_dec (
                .clk    (clk),
                .rst_n  (rst_n),
                .mode   (mode[2*u +: 2]),
                .cp0_in (eff_cp0[u]),
                .cp1_in (eff_cp1[u]),
                .mr     (mr[u]),
                .q      (q_unit[u])
            );
            assign q[UNIT_BITS*u +: UNIT_BITS] = q_unit[u];
        end
    endgenerate

    p_top_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
endmodule

// File: tb/tb_dual_decade_counter.sv
`timescale 1ns/1ps
module tb_dual_decade_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode = 4'b0101;
    logic [1:0] cp0 = 2'b11, cp1 = 2'b11, mr = 2'b00;
    logic [0:0] link_en = 1'b0, link_src = 1'b0, link_dst = 1'b0;
    logic [7:0] q;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_decade_counter dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cp0(cp0), .cp1(cp1), .mr(mr),
        .link_en(link_en), .link_src(link_src), .link_dst(link_dst), .q(q)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Put both units in the given configuration and clear them.
    task automatic setup(input logic [3:0] m, input logic le, input logic ls, input logic ld);
        @(negedge clk);
        cp0 = 2'b11; cp1 = 2'b11; mr = 2'b11;
        mode = m; link_en = le; link_src = ls; link_dst = ld;
        repeat (3) @(negedge clk);
        mr = 2'b00;
        repeat (3) @(negedge clk);
    endtask

    // One low pulse on a stage clock: which 0 = cp0, 1 = cp1.
    task automatic pulse(input int u, input int which);
        @(negedge clk);
        if (which == 0) cp0[u] = 1'b0; else cp1[u] = 1'b0;
        repeat (6) @(negedge clk);
        if (which == 0) cp0[u] = 1'b1; else cp1[u] = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R9 reset", q, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_split;
        setup(4'b0000, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) pulse(0, 0);
        chk("R1 toggle x3", q, 8'h01);
        for (int i = 0; i < 7; i++) pulse(0, 1);
        chk("R2 mod5 x7", q, 8'h05);          // hi=2 -> 0101
        for (int i = 0; i < 3; i++) pulse(0, 1);
        chk("R2 mod5 wrap x10", q, 8'h01);
        chk("R3 split unit1 idle", {4'h0, q[7:4]}, 8'h00);
    endtask

    task automatic t_bcd;
        setup(4'b0101, 1'b0, 1'b0, 1'b0);
        for (int i = 1; i <= 12; i++) begin
            pulse(0, 0);
            chk($sformatf("R3 bcd step %0d", i), {4'h0, q[3:0]}, 8'(i % 10));
        end
        pulse(0, 1);
        chk("R3 bcd cp1 ignored", {4'h0, q[3:0]}, 8'h02);
    endtask

    task automatic t_biq;
        int highs;
        setup(4'b1010, 1'b0, 1'b0, 1'b0);
        highs = 0;
        for (int i = 1; i <= 10; i++) begin
            if (q[0]) highs++;
            pulse(0, 1);
            chk($sformatf("R4 biq step %0d", i), {4'h0, q[3:0]},
                8'({3'(i % 5), 1'((i / 5) % 2)}));
        end
        chk("R4 duty five of ten", 8'(highs), 8'd5);
        pulse(0, 0);
        chk("R4 biq cp0 ignored", {4'h0, q[3:0]}, 8'h00);
    endtask

    task automatic t_clear;
        setup(4'b0101, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) pulse(0, 0);
        for (int i = 0; i < 2; i++) pulse(1, 0);
        chk("R5 pre clear", q, 8'h23);
        @(negedge clk);
        mr[0] = 1'b1;
        #1;
        chk("R5 immediate clear, other kept", q, 8'h20);
        pulse(0, 0);
        chk("R6 fall ignored in clear", q, 8'h20);
        mr[0] = 1'b0;
        repeat (3) @(negedge clk);
        pulse(0, 0);
        chk("R6 first fall after release", q, 8'h21);
        mr = 2'b11;
        #1;
        chk("R5 both cleared", q, 8'h00);
        repeat (2) @(negedge clk);
        mr = 2'b00;
    endtask

    task automatic t_link100;
        setup(4'b0101, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 37; i++) pulse(0, 0);
        chk("R7 link bcd 37", q, 8'h37);
        pulse(1, 0);
        chk("R7 linked pin ignored", q, 8'h37);
        for (int i = 0; i < 62; i++) pulse(0, 0);
        chk("R8 count 99", q, 8'h99);
        pulse(0, 0);
        chk("R8 divide 100 wrap", q, 8'h00);
    endtask

    task automatic t_link25;
        setup(4'b0000, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 13; i++) pulse(0, 1);
        chk("R8 divide 25 at 13", q, 8'h46);
        for (int i = 0; i < 12; i++) pulse(0, 1);
        chk("R8 divide 25 wrap", q, 8'h00);
    endtask

    task automatic t_link4;
        setup(4'b0000, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) pulse(0, 0);
        chk("R8 divide 4 at 3", q, 8'h11);
        pulse(0, 0);
        chk("R8 divide 4 wrap", q, 8'h00);
    endtask

    initial begin
        t_reset();
        t_split();
        t_bcd();
        t_biq();
        t_clear();
        t_link100();
        t_link25();
        t_link4();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule